// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte-wide stream into memory through a ring of receive descriptors. Software fills each descriptor with a buffer address and a capacity, then sets its ownership bit to give it to hardware. When a frame starts, the block fetches the current descriptor, writes the frame bytes one at a time into the named buffer, and writes a completion status back into the ownership word. That status carries the length, the first and last fragment marks and the error flags, and it clears ownership.

A frame longer than one buffer is spread over as many owned descriptors as it needs. If the current descriptor still belongs to software, the frame is discarded and a missed-frame count is bumped. The ring wraps to its base address after any descriptor whose end bit is set. Error flags arrive with the last byte and are copied into status, with an error summary bit formed from them.

The memory port is a single word-wide port with byte enables and a fixed read latency of one cycle. The ring base must be 16-byte aligned; each descriptor spans 16 bytes, with its status word at offset 0 and its buffer address at offset 8.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset `in_ready`, `mem_req` and `rx_ok` are low, `miss_count` is zero, and the first descriptor fetched is at `ring_base`.
- R2: For each descriptor used, the block reads the word at the descriptor address, then (only if bit 31 of that word is 1) the word at descriptor address + 8, before accepting any byte into that descriptor; no read is issued while `in_ready` is high.
- R3: Byte k of a fragment is written to buffer address + k: `mem_addr` is that address with bits 1:0 cleared and `mem_be` has only bit (address mod 4) set, with the byte on every lane of `mem_wdata`.
- R4: Completion writes one full word (`mem_be` = 4'hF) to the descriptor address with bit 31 = 0, bit 29 = 1 on the first fragment of a frame, bit 28 = 1 on the last fragment, bits 13:0 = bytes stored in that fragment, and bits 27:22 and 18:14 zero.
- R5: On the last fragment, bit 20 copies the runt flag and bit 19 the CRC flag seen with the last byte; bit 21 is set exactly when bit 20 or bit 19 is set. Earlier fragments carry all three as 0.
- R6: Bit 30 of the status word keeps the value it had when the descriptor was fetched.
- R7: After a descriptor whose bit 30 was 1, the next descriptor is at `ring_base`; otherwise it is 16 bytes further on.
- R8: When a frame reaches the buffer capacity before its last byte, that fragment is closed with bit 28 = 0 and storing continues in the next descriptor, whose status has bit 29 = 0. A last byte landing exactly at capacity closes the frame with no further fragment.
- R9: If a fetched status word has bit 31 = 0, the remaining bytes of the frame are accepted and discarded up to its last byte, `miss_count` rises by one, no memory write occurs, and the same descriptor is fetched for the next frame.
- R10: `rx_ok` is high for exactly one cycle per frame, in the cycle that writes the status of its last fragment.
- R11: Buffer capacity is bits 13:3 of the fetched status word times 8; bits 2:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_base | input | ADDR_W | Byte address of descriptor 0, 16-byte aligned |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte taken this cycle when `in_valid` is high |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the final one of the frame |
| in_runt | input | 1 | Runt flag, sampled with the last byte |
| in_crc_err | input | 1 | CRC error flag, sampled with the last byte |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_ok | output | 1 | Frame-available pulse |
| miss_count | output | MISS_W | Frames discarded for lack of an owned descriptor |

## Verification
A stale ring index shows at the ports on the very next descriptor fetch, as a read at the wrong address one cycle after a frame starts. A byte counter that drifts puts a byte on the wrong lane or address in the same cycle the byte is accepted, and a wrong length in the status word one cycle after the fragment ends. A lost end bit or a wrong ownership decision stays hidden until the ring wraps or a descriptor is refused, so the stimulus drives the ring through a wrap, a refused descriptor and a frame cut off part way.

// File: rtl/rxr_pkg.sv
// Package for the receive descriptor ring writer.
// Holds the controller states, the status word bit positions and the
// function that builds a completion status word.
package rxr_pkg;

    localparam int LEN_W       = 14;  // length / capacity field width
    localparam int BIT_OWN     = 31;  // 1: descriptor held by hardware
    localparam int BIT_END     = 30;  // 1: last descriptor of the ring
    localparam int BIT_FIRST   = 29;  // fragment opens a frame
    localparam int BIT_LAST    = 28;  // fragment closes a frame
    localparam int BIT_ERR     = 21;  // error summary
    localparam int BIT_RUNT    = 20;  // runt frame
    localparam int BIT_CRC     = 19;  // CRC error
    localparam int CAP_LO      = 3;   // capacity field low bit
    localparam int DESC_SHIFT  = 4;   // 16 bytes per descriptor
    localparam int ADDR_OFS    = 8;   // buffer address word offset

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a frame
        ST_RD0,    // read status word
        ST_WT0,    // status word returning
        ST_RD2,    // read buffer address
        ST_WT2,    // buffer address returning
        ST_DATA,   // storing bytes
        ST_WB,     // writing completion status
        ST_DROP    // discarding the rest of a frame
    } rxr_state_e;

    // Compose the completion status word for one fragment.
    function automatic logic [31:0] rxr_status(
        input logic             end_bit,
        input logic             first,
        input logic             last,
        input logic             runt,
        input logic             crc,
        input logic [LEN_W-1:0] len
    );
        logic [31:0] w;
        w                = '0;
        w[BIT_END]       = end_bit;
        w[BIT_FIRST]     = first;
        w[BIT_LAST]      = last;
        w[BIT_RUNT]      = runt;
        w[BIT_CRC]       = crc;
        w[BIT_ERR]       = runt | crc;
        w[LEN_W-1:0]     = len;
        return w;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
// Ring index keeper.
// Holds the index of the current descriptor and turns it into a byte
// address off the ring base. Assumes ring_base is 16-byte aligned.
module rxr_ring_ptr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] desc_addr
);
    import rxr_pkg::*;

    localparam int OFS_W = IDX_W + DESC_SHIFT;

    logic [IDX_W-1:0] idx_q;
    logic [OFS_W-1:0] ofs;

    // Step or wrap the index when a descriptor is retired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (advance)
            idx_q <= wrap ? '0 : idx_q + 1'b1;
    end

    // Byte offset of the current descriptor.
    always_comb begin
        ofs = {idx_q, {DESC_SHIFT{1'b0}}};
        desc_addr = ring_base + ADDR_W'(ofs);
    end

endmodule

// File: rtl/rxr_frag_ctr.sv
// Fragment byte counter.
// Loads a buffer capacity (field times 8) and counts bytes stored into the
// current buffer; flags the byte that fills the buffer. Assumes a nonzero
// capacity is handed over.
module rxr_frag_ctr #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] cap_word,
    input  logic             step,
    output logic [LEN_W-1:0] count,
    output logic             cap_hit
);
    localparam int LOW_W = 3;

    logic [LEN_W-1:0] cap_q;

    // Capture capacity and clear the count, or count one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            count <= '0;
        end else if (load) begin
            cap_q <= {cap_word[LEN_W-1:LOW_W], {LOW_W{1'b0}}};
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // The byte now being stored would fill the buffer.
    always_comb cap_hit = (count + 1'b1) == cap_q;

endmodule

// File: rtl/rxr_mem_mux.sv
// Memory port steering.
// Selects address, enables and write data for the memory port from the
// controller state: descriptor reads, byte stores and status write-back.
module rxr_mem_mux #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 14
) (
    input  rxr_pkg::rxr_state_e state,
    input  logic [ADDR_W-1:0]   desc_addr,
    input  logic [ADDR_W-1:0]   buf_addr,
    input  logic [LEN_W-1:0]    count,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic [31:0]         status_word,
    output logic                mem_req,
    output logic                mem_we,
    output logic [3:0]          mem_be,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [31:0]         mem_wdata
);
    import rxr_pkg::*;

    logic [ADDR_W-1:0] byte_addr;

    // Drive one access per cycle according to state.
    always_comb begin
        byte_addr = buf_addr + ADDR_W'(count);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = 4'h0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        unique case (state)
            ST_RD0: begin
                mem_req = 1'b1;
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(ADDR_OFS);
            end
            ST_DATA: begin
                mem_req   = in_valid;
                mem_we    = in_valid;
                mem_addr  = {byte_addr[ADDR_W-1:2], 2'b00};
                mem_be    = 4'b0001 << byte_addr[1:0];
                mem_wdata = {4{in_data}};
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = status_word;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxr_ring_writer.sv
// Receive descriptor ring writer (top).
// Takes frames from a byte stream, stores them into buffers named by an
// ownership-flagged descriptor ring in memory and writes completion status
// back. Assumes a memory with one-cycle read latency and no write stall,
// a 16-byte aligned ring base and ADDR_W no wider than 32.
module rxr_ring_writer #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_runt,
    input  logic              in_crc_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              rx_ok,
    output logic [MISS_W-1:0] miss_count
);
    import rxr_pkg::*;

    rxr_state_e        state_q;
    logic              end_q;
    logic              first_q;
    logic              last_q;
    logic              runt_q;
    logic              crc_q;
    logic [ADDR_W-1:0] buf_q;
    logic [MISS_W-1:0] miss_q;
    logic [ADDR_W-1:0] desc_addr;
    logic [LEN_W-1:0]  count;
    logic              cap_hit;
    logic              take;
    logic              owned;
    logic [31:0]       status_word;
    logic              unused_rdata;

    assign take         = in_valid && (state_q == ST_DATA);
    assign owned        = mem_rdata[BIT_OWN];
    assign unused_rdata = ^mem_rdata;

    rxr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .advance   (state_q == ST_WB),
        .wrap      (end_q),
        .desc_addr (desc_addr)
    );

    rxr_frag_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_WT0 && owned),
        .cap_word (mem_rdata[LEN_W-1:0]),
        .step     (take),
        .count    (count),
        .cap_hit  (cap_hit)
    );

    rxr_mem_mux #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mux (
        .state       (state_q),
        .desc_addr   (desc_addr),
        .buf_addr    (buf_q),
        .count       (count),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .status_word (status_word),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_be      (mem_be),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    // Status word for the fragment now closing.
    always_comb status_word = rxr_status(end_q, first_q, last_q, runt_q, crc_q, count);

    // Sequence descriptor fetch, byte storage, write-back and discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            end_q   <= 1'b0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
            runt_q  <= 1'b0;
            crc_q   <= 1'b0;
            buf_q   <= '0;
            miss_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        first_q <= 1'b1;
                        state_q <= ST_RD0;
                    end
                end
                ST_RD0: state_q <= ST_WT0;
                ST_WT0: begin
                    if (owned) begin
                        end_q   <= mem_rdata[BIT_END];
                        state_q <= ST_RD2;
                    end else begin
                        miss_q  <= miss_q + 1'b1;
                        state_q <= ST_DROP;
                    end
                end
                ST_RD2: state_q <= ST_WT2;
                ST_WT2: begin
                    buf_q   <= mem_rdata[ADDR_W-1:0];
                    state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (take && in_last) begin
                        last_q  <= 1'b1;
                        runt_q  <= in_runt;
                        crc_q   <= in_crc_err;
                        state_q <= ST_WB;
                    end else if (take && cap_hit) begin
                        last_q  <= 1'b0;
                        runt_q  <= 1'b0;
                        crc_q   <= 1'b0;
                        state_q <= ST_WB;
                    end
                end
                ST_WB: begin
                    first_q <= 1'b0;
                    state_q <= last_q ? ST_IDLE : ST_RD0;
                end
                ST_DROP: begin
                    if (in_valid && in_last)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Stream acceptance, frame pulse and discard count.
    always_comb begin
        in_ready   = (state_q == ST_DATA) || (state_q == ST_DROP);
        rx_ok      = (state_q == ST_WB) && last_q;
        miss_count = miss_q;
    end

endmodule

// File: rtl/rxr_ring_writer_chk.sv
// Property checker for the receive descriptor ring writer, bound to the top.
// Watches the memory port, stream ready, frame pulse and discard count.
module rxr_ring_writer_chk #(
    parameter int ADDR_W = 32,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              rx_ok,
    input logic [MISS_W-1:0] miss_count
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!in_ready && !mem_req && !rx_ok && miss_count == '0));

    assert_no_read_while_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !(mem_req && !mem_we));

    assert_byte_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1 && mem_addr[1:0] == 2'b00));

    assert_status_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF) |-> !mem_wdata[31]);

    assert_error_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF) |-> (mem_wdata[21] == (mem_wdata[20] | mem_wdata[19])));

    assert_miss_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));

    assert_frame_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> !rx_ok);

    assert_pulse_with_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |-> (mem_req && mem_we && mem_be == 4'hF && mem_wdata[28]));

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) u_chk (.*);

// File: tb/rxr_ring_writer_bench.sv
// Scoreboard bench: the driver task models the ring and queues expected
// memory accesses; the monitor pops and compares them mid-cycle.
module rxr_ring_writer_bench;

    localparam int ADDR_W = 32;
    localparam int MISS_W = 16;
    localparam int NDESC  = 4;
    localparam logic [31:0] RING = 32'h100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_base = RING;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_data = '0;
    logic              in_last = 1'b0;
    logic              in_runt = 1'b0;
    logic              in_crc_err = 1'b0;
    logic              mem_req, mem_we;
    logic [3:0]        mem_be;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata;
    logic              rx_ok;
    logic [MISS_W-1:0] miss_count;

    always #5 clk = ~clk;

    rxr_ring_writer #(.ADDR_W(ADDR_W), .IDX_W(8), .MISS_W(MISS_W)) u_rxr_ring_writer (.*);

    // Memory model with bench-side write port.
    logic [31:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [31:0] tb_addr = '0;
    logic [31:0] tb_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else begin
            if (tb_we) mem[tb_addr[9:2]] <= tb_data;
            if (mem_req && mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard queues.
    logic [31:0] q_rd[$];
    logic [43:0] q_bw[$];  // {addr, be, byte}
    logic [63:0] q_wb[$];  // {addr, data}
    int          rxok_seen = 0;
    int          exp_rxok = 0;
    int          exp_miss = 0;

    // Monitor: compares every memory access in the middle of its cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_ok) rxok_seen++;
            if (mem_req && !mem_we) begin
                if (q_rd.size() == 0) chk(0, "R2 R7 R9 unexpected read", 64'(mem_addr), 64'h0);
                else begin
                    logic [31:0] e;
                    e = q_rd.pop_front();
                    chk(mem_addr == e, "R2 R7 descriptor read address", 64'(mem_addr), 64'(e));
                end
            end else if (mem_req && mem_we && mem_be == 4'hF) begin
                if (q_wb.size() == 0) chk(0, "R4 R9 unexpected status write", {mem_addr, mem_wdata}, 64'h0);
                else begin
                    logic [63:0] e;
                    e = q_wb.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R4 R5 R6 R8 status write", {mem_addr, mem_wdata}, e);
                end
            end else if (mem_req && mem_we) begin
                if (q_bw.size() == 0) chk(0, "R3 R9 unexpected byte write", {mem_addr, mem_be, mem_wdata[7:0]}, 64'h0);
                else begin
                    logic [43:0] e;
                    logic [7:0]  lane;
                    e = q_bw.pop_front();
                    lane = '0;
                    for (int b = 0; b < 4; b++) if (mem_be[b]) lane = mem_wdata[8*b +: 8];
                    chk({mem_addr, mem_be, lane} == e, "R3 byte write", 64'({mem_addr, mem_be, lane}), 64'(e));
                end
            end
        end
    end

    // Bench ring model.
    bit          m_own [NDESC];
    bit          m_end [NDESC];
    int          m_cap [NDESC];
    int          m_ptr = 0;

    function automatic logic [31:0] daddr(int i);
        return RING + 32'(16 * i);
    endfunction

    function automatic logic [31:0] baddr(int i);
        return 32'h200 + 32'(i * 128 + i);
    endfunction

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    // Hand descriptor i to hardware; capacity field in bits 13:0 (R11).
    task automatic arm(input int i, input logic [13:0] capf, input bit e);
        poke(daddr(i), 32'h8000_0000 | (32'(e) << 30) | 32'(capf));
        poke(daddr(i) + 32'd8, baddr(i));
        m_own[i] = 1'b1;
        m_end[i] = e;
        m_cap[i] = int'(capf & 14'h3FF8);
    endtask

    // Driver: model the ring, queue expected accesses, then drive the frame.
    task automatic send_frame(input int len, input bit runt, input bit crc, input logic [7:0] seed);
        int k = 0;
        bit first = 1'b1;
        forever begin
            int n;
            bit ls;
            logic [31:0] w;
            q_rd.push_back(daddr(m_ptr));
            if (!m_own[m_ptr]) begin
                exp_miss++;
                break;
            end
            q_rd.push_back(daddr(m_ptr) + 32'd8);
            n = (len - k < m_cap[m_ptr]) ? len - k : m_cap[m_ptr];
            for (int j = 0; j < n; j++) begin
                logic [31:0] a;
                a = baddr(m_ptr) + 32'(j);
                q_bw.push_back({a[31:2], 2'b00, 4'b0001 << a[1:0], seed + 8'(k + j)});
            end
            k += n;
            ls = (k == len);
            w = '0;
            w[30] = m_end[m_ptr];
            w[29] = first;
            w[28] = ls;
            w[21] = ls & (runt | crc);
            w[20] = ls & runt;
            w[19] = ls & crc;
            w[13:0] = 14'(n);
            q_wb.push_back({daddr(m_ptr), w});
            m_own[m_ptr] = 1'b0;
            if (ls) exp_rxok++;
            m_ptr = m_end[m_ptr] ? 0 : m_ptr + 1;
            first = 1'b0;
            if (ls) break;
        end
        for (int j = 0; j < len; j++) begin
            bit acc;
            in_valid = 1'b1;
            in_data = seed + 8'(j);
            in_last = (j == len - 1);
            in_runt = runt;
            in_crc_err = crc;
            do begin
                @(negedge clk);
                acc = in_ready;
                @(posedge clk); #1;
            end while (!acc);
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        in_runt = 1'b0;
        in_crc_err = 1'b0;
    endtask

    // Let the design drain, then check queues, pulse count and miss count.
    task automatic settle(input string tag);
        int n = 0;
        while ((q_rd.size() + q_bw.size() + q_wb.size()) != 0 && n < 300) begin
            @(posedge clk); n++;
        end
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk((q_rd.size() + q_bw.size() + q_wb.size()) == 0, {tag, " R2 R3 R4 pending accesses"},
            64'(q_rd.size() + q_bw.size() + q_wb.size()), 64'h0);
        chk(rxok_seen == exp_rxok, {tag, " R10 frame pulses"}, 64'(rxok_seen), 64'(exp_rxok));
        chk(miss_count == MISS_W'(exp_miss), {tag, " R9 miss count"}, 64'(miss_count), 64'(exp_miss));
        @(posedge clk); #1;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 64'h0, 64'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset.
        chk(!in_ready && !mem_req && !rx_ok, "R1 idle outputs", {61'h0, in_ready, mem_req, rx_ok}, 64'h0);
        chk(miss_count == '0, "R1 miss count cleared", 64'(miss_count), 64'h0);
        @(posedge clk); #1;

        for (int i = 0; i < NDESC; i++) arm(i, 14'd64, i == NDESC - 1);
        send_frame(10, 1'b0, 1'b0, 8'h10);   // R1 first fetch at base, R3, R4
        settle("plain");
        send_frame(5, 1'b1, 1'b0, 8'h40);    // R5 runt
        settle("runt");
        send_frame(20, 1'b0, 1'b1, 8'h70);   // R5 crc
        settle("crc");
        send_frame(64, 1'b1, 1'b1, 8'hA0);   // R5 both, R8 exact fit, R6 end bit
        settle("exact");
        send_frame(8, 1'b0, 1'b0, 8'h01);    // R9 ring exhausted after wrap, R7
        settle("refused");

        arm(0, 14'h0047, 1'b0);              // R11 low bits ignored, capacity 64
        arm(1, 14'd64, 1'b0);
        send_frame(100, 1'b0, 1'b1, 8'h20);  // R8 split over two, R11
        settle("split");

        arm(2, 14'd64, 1'b0);
        send_frame(70, 1'b0, 1'b0, 8'h90);   // R8 then R9 continuation refused
        settle("cutoff");

        arm(3, 14'd32, 1'b1);
        arm(0, 14'd64, 1'b0);
        send_frame(12, 1'b1, 1'b0, 8'hC0);   // R7 R6 end bit kept, then wrap
        settle("wrap");
        send_frame(3, 1'b0, 1'b0, 8'hE0);    // R7 lands at base again
        settle("after-wrap");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule